// File: doc/BRIEF.md
# Priority Interrupt Acceptance Unit

This block sits beside a processor's sequencer and decides, once per idle cycle, whether an incoming interrupt request is taken. The request arrives as a 3-bit priority code, where 0 means no request. The code is compared with the 3-bit mask field of the current status word. When a request wins, the unit acknowledges it and stores the return state on the stack as three 16-bit write strobes. It then commits the new status word (supervisor bit set, mask raised to the taken level) and the decremented stack pointer. In the same cycle it asks for the handler address at the vector table slot.

A return command runs the same frame in reverse. Three read strobes recover the status word and the two halves of the program counter, and a commit cycle restores all three registers. The unit performs no memory cycles of its own. It issues one strobe per cycle and takes read data back in the same cycle.

Top module: `irq_accept_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `mem_req`, `iack`, `sr_wr`, `sp_wr`, `pc_wr` and `vec_fetch` are all 0.
- R2: A request of level 1 to 6 is taken only when it is strictly greater than the status word mask in bits 10..8. A request at or below the mask produces no acknowledge and no strobe.
- R3: Level 7 is taken regardless of the mask, once per rising transition of the request code to 7. A level 7 held for many cycles is taken only once. A transition to 7 that occurs while the unit is busy is remembered and taken at the next idle cycle, ahead of any lower level.
- R4: In the three cycles after acceptance the unit writes 16-bit words in this order: PC[15:0] at SP-2, then PC[31:16] at SP-4, then the old status word at SP-6 (`mem_we`=1).
- R5: In the fourth cycle `sr_wr` carries the old status word with bit 13 (supervisor) set to 1 and bits 10..8 set to the taken level, all other bits unchanged. In the same cycle `sp_wr` carries SP-6.
- R6: In the same fourth cycle `vec_fetch` is 1 and `vec_addr` is the vector number times 4. The vector number is `vec_num` when `vec_auto`=0, and 24 plus the taken level when `vec_auto`=1.
- R7: `iack` is 1 for exactly the first push cycle, with `iack_level` giving the taken level.
- R8: A return command in an idle cycle reads the status word at SP, PC[31:16] at SP+2 and PC[15:0] at SP+4 (`mem_we`=0). The next cycle restores the status word, the PC and SP+6 through `sr_wr`, `pc_wr` and `sp_wr`.
- R9: While `busy` is 1 (four cycles per sequence), neither requests nor return commands start a new sequence.
- R10: When a return command and a takeable request meet in the same idle cycle, the return runs first. The request is judged afterwards against the restored mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_level | input | 3 | Encoded request priority, 0 = none |
| vec_num | input | 8 | Vector number supplied by the device |
| vec_auto | input | 1 | 1 selects the automatic vector 24 + level |
| rte_cmd | input | 1 | Return-from-exception command |
| sr_in | input | 16 | Current status word |
| pc_in | input | 32 | Current program counter |
| sp_in | input | 32 | Current supervisor stack pointer |
| mem_rdata | input | 16 | Read data for the current read strobe, same cycle |
| busy | output | 1 | A sequence is running |
| mem_req | output | 1 | Memory word strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| iack | output | 1 | Acceptance acknowledge |
| iack_level | output | 3 | Level being acknowledged |
| sr_wr | output | 1 | Load the status word |
| sr_out | output | 16 | New status word |
| sp_wr | output | 1 | Load the stack pointer |
| sp_out | output | 32 | New stack pointer |
| pc_wr | output | 1 | Load the program counter (return only) |
| pc_out | output | 32 | Restored program counter |
| vec_fetch | output | 1 | Fetch the handler address |
| vec_addr | output | 32 | Vector table byte address |

## Verification
A corrupted level or vector register shows up at the ports four cycles after acceptance, in the status word written back and in the table address. A wrong capture of PC or SP shows on the very first write strobe. A stale level-7 pending bit shows either as a missing acknowledge or as a second acknowledge at the first idle cycle after a sequence ends. A wrong sequencer state shows in the same cycle as an out-of-order address or direction on the strobe. Every cycle's outputs are compared against a behavioural model, so any of these faults is caught within one cycle of reaching the ports.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  localparam int LVL_W        = 3;
  localparam int VEC_W        = 8;
  localparam int WORD_W       = 16;
  localparam int ADDR_W       = 32;
  localparam int PC_W         = 32;
  localparam int SR_S_BIT     = 13;
  localparam int SR_MASK_LSB  = 8;
  localparam int AUTOVEC_BASE = 24;
  localparam int WORD_BYTES   = WORD_W / 8;
  localparam int VEC_SHIFT    = 2;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_PUSH_SR,
    ST_ENTER,
    ST_POP_SR,
    ST_POP_HI,
    ST_POP_LO,
    ST_LEAVE
  } seq_state_e;

  function automatic logic [LVL_W-1:0] mask_of(input logic [WORD_W-1:0] sr);
    return sr[SR_MASK_LSB +: LVL_W];
  endfunction

  function automatic logic [WORD_W-1:0] entry_status(input logic [WORD_W-1:0] sr,
                                                     input logic [LVL_W-1:0]  lvl);
    logic [WORD_W-1:0] r;
    r = sr;
    r[SR_S_BIT] = 1'b1;
    r[SR_MASK_LSB +: LVL_W] = lvl;
    return r;
  endfunction

  function automatic logic [VEC_W-1:0] pick_vector(input logic             use_auto,
                                                   input logic [VEC_W-1:0] dev_vec,
                                                   input logic [LVL_W-1:0] lvl);
    return use_auto ? (VEC_W'(AUTOVEC_BASE) + VEC_W'(lvl)) : dev_vec;
  endfunction

  function automatic logic [ADDR_W-1:0] vector_address(input logic [VEC_W-1:0] vec);
    return ADDR_W'(vec) << VEC_SHIFT;
  endfunction

  function automatic logic [ADDR_W-1:0] frame_slot(input logic [ADDR_W-1:0] sp,
                                                   input int               words);
    return sp + ADDR_W'(words * WORD_BYTES);
  endfunction

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
  import irq_accept_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] req_level,
  input  logic [LVL_W-1:0] cur_mask,
  input  logic             allow,
  output logic             take,
  output logic [LVL_W-1:0] take_level,
  output logic             nmi_rise,
  output logic             nmi_pending
);

  localparam logic [LVL_W-1:0] TOP_LVL = '1;

  logic prev_top_q;
  logic pend_q;
  logic maskable_ok;

  assign nmi_rise    = (req_level == TOP_LVL) && !prev_top_q;
  assign nmi_pending = pend_q | nmi_rise;
  assign maskable_ok = (req_level != TOP_LVL) && (req_level > cur_mask);
  assign take        = allow && (nmi_pending || maskable_ok);
  assign take_level  = nmi_pending ? TOP_LVL : req_level;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_top_q <= 1'b0;
      pend_q     <= 1'b0;
    end else begin
      prev_top_q <= (req_level == TOP_LVL);
      pend_q     <= nmi_pending && !take;
    end
  end

endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irq_accept_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_int,
  input  logic              start_rte,
  input  logic [LVL_W-1:0]  int_level,
  input  logic [VEC_W-1:0]  int_vector,
  input  logic [WORD_W-1:0] sr_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              idle,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              iack,
  output logic [LVL_W-1:0]  iack_level,
  output logic              sr_wr,
  output logic [WORD_W-1:0] sr_out,
  output logic              sp_wr,
  output logic [ADDR_W-1:0] sp_out,
  output logic              pc_wr,
  output logic [PC_W-1:0]   pc_out,
  output logic              vec_fetch,
  output logic [ADDR_W-1:0] vec_addr
);

  localparam int FRAME_WORDS = (PC_W / WORD_W) + 1;

  seq_state_e        st_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [VEC_W-1:0]  vec_q;
  logic [WORD_W-1:0] sr_q;
  logic [PC_W-1:0]   pc_q;
  logic [ADDR_W-1:0] sp_q;

  assign idle = (st_q == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lvl_q <= '0;
      vec_q <= '0;
      sr_q  <= '0;
      pc_q  <= '0;
      sp_q  <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_rte) begin
            sp_q <= sp_in;
            st_q <= ST_POP_SR;
          end else if (start_int) begin
            lvl_q <= int_level;
            vec_q <= int_vector;
            sr_q  <= sr_in;
            pc_q  <= pc_in;
            sp_q  <= sp_in;
            st_q  <= ST_PUSH_LO;
          end
        end
        ST_PUSH_LO: st_q <= ST_PUSH_HI;
        ST_PUSH_HI: st_q <= ST_PUSH_SR;
        ST_PUSH_SR: st_q <= ST_ENTER;
        ST_ENTER:   st_q <= ST_IDLE;
        ST_POP_SR: begin
          sr_q <= mem_rdata;
          st_q <= ST_POP_HI;
        end
        ST_POP_HI: begin
          pc_q[PC_W-1:WORD_W] <= mem_rdata;
          st_q <= ST_POP_LO;
        end
        ST_POP_LO: begin
          pc_q[WORD_W-1:0] <= mem_rdata;
          st_q <= ST_LEAVE;
        end
        ST_LEAVE:   st_q <= ST_IDLE;
        default:    st_q <= ST_IDLE;
      endcase
    end
  end

  assign iack_level = lvl_q;
  assign vec_addr   = vector_address(vec_q);
  assign pc_out     = pc_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    iack      = 1'b0;
    sr_wr     = 1'b0;
    sr_out    = '0;
    sp_wr     = 1'b0;
    sp_out    = '0;
    pc_wr     = 1'b0;
    vec_fetch = 1'b0;
    unique case (st_q)
      ST_PUSH_LO: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = frame_slot(sp_q, -1);
        mem_wdata = pc_q[WORD_W-1:0];
        iack      = 1'b1;
      end
      ST_PUSH_HI: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = frame_slot(sp_q, -2);
        mem_wdata = pc_q[PC_W-1:WORD_W];
      end
      ST_PUSH_SR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = frame_slot(sp_q, -FRAME_WORDS);
        mem_wdata = sr_q;
      end
      ST_ENTER: begin
        sr_wr     = 1'b1;
        sr_out    = entry_status(sr_q, lvl_q);
        sp_wr     = 1'b1;
        sp_out    = frame_slot(sp_q, -FRAME_WORDS);
        vec_fetch = 1'b1;
      end
      ST_POP_SR: begin
        mem_req  = 1'b1;
        mem_addr = sp_q;
      end
      ST_POP_HI: begin
        mem_req  = 1'b1;
        mem_addr = frame_slot(sp_q, 1);
      end
      ST_POP_LO: begin
        mem_req  = 1'b1;
        mem_addr = frame_slot(sp_q, 2);
      end
      ST_LEAVE: begin
        sr_wr  = 1'b1;
        sr_out = sr_q;
        sp_wr  = 1'b1;
        sp_out = frame_slot(sp_q, FRAME_WORDS);
        pc_wr  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/irq_accept_unit.sv
module irq_accept_unit
  import irq_accept_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LVL_W-1:0]  req_level,
  input  logic [VEC_W-1:0]  vec_num,
  input  logic              vec_auto,
  input  logic              rte_cmd,
  input  logic [WORD_W-1:0] sr_in,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [ADDR_W-1:0] sp_in,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              iack,
  output logic [LVL_W-1:0]  iack_level,
  output logic              sr_wr,
  output logic [WORD_W-1:0] sr_out,
  output logic              sp_wr,
  output logic [ADDR_W-1:0] sp_out,
  output logic              pc_wr,
  output logic [PC_W-1:0]   pc_out,
  output logic              vec_fetch,
  output logic [ADDR_W-1:0] vec_addr
);

  logic             seq_idle;
  logic             gate_allow;
  logic             rte_go;
  logic             take;
  logic [LVL_W-1:0] take_level;
  logic             nmi_rise;
  logic             nmi_pending;
  logic [VEC_W-1:0] chosen_vec;

  assign gate_allow = seq_idle && !rte_cmd;
  assign rte_go     = seq_idle && rte_cmd;
  assign chosen_vec = pick_vector(vec_auto, vec_num, take_level);
  assign busy       = !seq_idle;

  irq_level_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_level   (req_level),
    .cur_mask    (mask_of(sr_in)),
    .allow       (gate_allow),
    .take        (take),
    .take_level  (take_level),
    .nmi_rise    (nmi_rise),
    .nmi_pending (nmi_pending)
  );

  irq_frame_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_int  (take),
    .start_rte  (rte_go),
    .int_level  (take_level),
    .int_vector (chosen_vec),
    .sr_in      (sr_in),
    .pc_in      (pc_in),
    .sp_in      (sp_in),
    .mem_rdata  (mem_rdata),
    .idle       (seq_idle),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .iack       (iack),
    .iack_level (iack_level),
    .sr_wr      (sr_wr),
    .sr_out     (sr_out),
    .sp_wr      (sp_wr),
    .sp_out     (sp_out),
    .pc_wr      (pc_wr),
    .pc_out     (pc_out),
    .vec_fetch  (vec_fetch),
    .vec_addr   (vec_addr)
  );

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
  import irq_accept_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              iack,
  input logic [LVL_W-1:0]  iack_level,
  input logic [WORD_W-1:0] sr_in,
  input logic              sr_wr,
  input logic [WORD_W-1:0] sr_out,
  input logic              sp_wr,
  input logic              pc_wr,
  input logic              vec_fetch,
  input logic [ADDR_W-1:0] vec_addr,
  input logic              nmi_rise
);

  a_r9_strobe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req || sr_wr || sp_wr) |-> busy);

  a_r7_ack_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> !$past(busy));

  a_r2_ack_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && iack_level != '1) |-> (iack_level > $past(sr_in[SR_MASK_LSB +: LVL_W])));

  a_r4_push_descends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we)) |->
      (mem_addr == $past(mem_addr) - ADDR_W'(WORD_BYTES)));

  a_r8_pop_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && $past(mem_req && !mem_we)) |->
      (mem_addr == $past(mem_addr) + ADDR_W'(WORD_BYTES)));

  a_r5_entry_status: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> (sr_wr && sp_wr && sr_out[SR_S_BIT] &&
                   sr_out[SR_MASK_LSB +: LVL_W] == $past(iack_level, 3)));

  a_r6_vector_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> (vec_addr[VEC_SHIFT-1:0] == '0 &&
                   vec_addr < (ADDR_W'(1) << (VEC_W + VEC_SHIFT))));

  a_r8_leave_restores: assert property (@(posedge clk) disable iff (!rst_n)
    pc_wr |-> (sr_wr && sp_wr && !vec_fetch));

  a_r3_held_top_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iack_level == '1 && iack) && $stable(iack_level)) |-> !nmi_rise || !$past(nmi_rise));

endmodule

bind irq_accept_unit irq_accept_chk u_chk (.*);

// File: tb/test_irq_accept_unit.sv
`timescale 1ns/1ps
module test_irq_accept_unit;

  localparam logic [31:0] STK_BASE = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  req_level = '0;
  logic [7:0]  vec_num = '0;
  logic        vec_auto = 1'b0;
  logic        rte_cmd = 1'b0;
  logic [15:0] cpu_sr = 16'h0000;
  logic [31:0] cpu_pc = 32'h0;
  logic [31:0] cpu_sp = 32'h0;
  logic [15:0] mem_rdata;
  logic        busy, mem_req, mem_we, iack, sr_wr, sp_wr, pc_wr, vec_fetch;
  logic [31:0] mem_addr, sp_out, pc_out, vec_addr;
  logic [15:0] mem_wdata, sr_out;
  logic [2:0]  iack_level;

  always #4 clk = ~clk;

  irq_accept_unit i_irq_accept_unit (
    .clk(clk), .rst_n(rst_n), .req_level(req_level), .vec_num(vec_num),
    .vec_auto(vec_auto), .rte_cmd(rte_cmd), .sr_in(cpu_sr), .pc_in(cpu_pc),
    .sp_in(cpu_sp), .mem_rdata(mem_rdata), .busy(busy), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .iack(iack),
    .iack_level(iack_level), .sr_wr(sr_wr), .sr_out(sr_out), .sp_wr(sp_wr),
    .sp_out(sp_out), .pc_wr(pc_wr), .pc_out(pc_out), .vec_fetch(vec_fetch),
    .vec_addr(vec_addr)
  );

  // stack RAM seen by the unit
  logic [15:0] ram [0:63];
  function automatic int slot(input logic [31:0] a);
    return int'((a - STK_BASE) >> 1) & 63;
  endfunction
  always_comb mem_rdata = ram[slot(mem_addr)];
  always @(posedge clk) begin
    if (mem_req && mem_we) ram[slot(mem_addr)] <= mem_wdata;
    if (sr_wr) cpu_sr <= sr_out;
    if (sp_wr) cpu_sp <= sp_out;
    if (pc_wr) cpu_pc <= pc_out;
  end

  // behavioural reference model
  typedef struct {
    bit req; bit we; logic [31:0] addr; logic [15:0] wd;
    bit ack; logic [2:0] al;
    bit srw; logic [15:0] sro; bit spw; logic [31:0] spo;
    bit pcw; logic [31:0] pco; bit vf; logic [31:0] va; bit bsy;
    string tag;
  } exp_t;

  exp_t        expq[$];
  logic [15:0] m_mem [0:63];
  logic [15:0] m_sr;
  logic [31:0] m_sp, m_pc;
  int          busy_left;
  bit          m_pend, m_prev7;
  string       cur_tag = "R1";
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 0;

  function automatic exp_t blank(input string t);
    exp_t e;
    e.req = 0; e.we = 0; e.addr = 0; e.wd = 0; e.ack = 0; e.al = 0;
    e.srw = 0; e.sro = 0; e.spw = 0; e.spo = 0; e.pcw = 0; e.pco = 0;
    e.vf = 0; e.va = 0; e.bsy = 0; e.tag = t;
    return e;
  endfunction

  task automatic model_accept(input int lvl);
    exp_t e;
    int vec;
    logic [15:0] nsr;
    vec = vec_auto ? 24 + lvl : int'(vec_num);
    e = blank({"R7 R4 ", cur_tag}); e.bsy = 1; e.req = 1; e.we = 1;
    e.addr = m_sp - 2; e.wd = m_pc[15:0]; e.ack = 1; e.al = 3'(lvl);
    expq.push_back(e);
    e = blank({"R4 ", cur_tag}); e.bsy = 1; e.req = 1; e.we = 1;
    e.addr = m_sp - 4; e.wd = m_pc[31:16];
    expq.push_back(e);
    e = blank({"R4 ", cur_tag}); e.bsy = 1; e.req = 1; e.we = 1;
    e.addr = m_sp - 6; e.wd = m_sr;
    expq.push_back(e);
    nsr = (m_sr & 16'hF8FF) | 16'h2000 | (16'(lvl) << 8);
    e = blank({"R5 R6 ", cur_tag}); e.bsy = 1; e.srw = 1; e.sro = nsr;
    e.spw = 1; e.spo = m_sp - 6; e.vf = 1; e.va = 32'(vec * 4);
    expq.push_back(e);
    m_mem[slot(m_sp - 2)] = m_pc[15:0];
    m_mem[slot(m_sp - 4)] = m_pc[31:16];
    m_mem[slot(m_sp - 6)] = m_sr;
    m_sr = nsr;
    m_sp = m_sp - 6;
  endtask

  task automatic model_return();
    exp_t e;
    e = blank({"R8 ", cur_tag}); e.bsy = 1; e.req = 1; e.addr = m_sp;
    expq.push_back(e);
    e.addr = m_sp + 2; expq.push_back(e);
    e.addr = m_sp + 4; expq.push_back(e);
    e = blank({"R8 ", cur_tag}); e.bsy = 1; e.srw = 1; e.sro = m_mem[slot(m_sp)];
    e.pcw = 1; e.pco = {m_mem[slot(m_sp + 2)], m_mem[slot(m_sp + 4)]};
    e.spw = 1; e.spo = m_sp + 6;
    expq.push_back(e);
    m_sr = e.sro; m_pc = e.pco; m_sp = m_sp + 6;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      busy_left = 0; m_pend = 0; m_prev7 = 0;
    end else begin
      bit rise, pend;
      rise = (req_level == 3'd7) && !m_prev7;
      pend = m_pend || rise;
      if (busy_left == 0) begin
        if (rte_cmd) begin            // R10: return wins over a request
          model_return(); busy_left = 4; m_pend = pend;
        end else if (pend) begin      // R3
          model_accept(7); busy_left = 4; m_pend = 0;
        end else if (req_level != 3'd7 && int'(req_level) > int'(m_sr[10:8])) begin
          model_accept(int'(req_level)); busy_left = 4; m_pend = pend;
        end else m_pend = pend;       // R2: ignored
      end else begin
        busy_left = busy_left - 1;    // R9: nothing starts while busy
        m_pend = pend;
      end
      m_prev7 = (req_level == 3'd7);
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      exp_t e;
      e = (expq.size() > 0) ? expq.pop_front() : blank(cur_tag);
      chk(e.tag, "busy", 32'(busy), 32'(e.bsy));
      chk(e.tag, "mem_req", 32'(mem_req), 32'(e.req));
      chk(e.tag, "iack", 32'(iack), 32'(e.ack));
      chk(e.tag, "sr_wr", 32'(sr_wr), 32'(e.srw));
      chk(e.tag, "sp_wr", 32'(sp_wr), 32'(e.spw));
      chk(e.tag, "pc_wr", 32'(pc_wr), 32'(e.pcw));
      chk(e.tag, "vec_fetch", 32'(vec_fetch), 32'(e.vf));
      if (e.req) begin
        chk(e.tag, "mem_we", 32'(mem_we), 32'(e.we));
        chk(e.tag, "mem_addr", mem_addr, e.addr);
        if (e.we) chk(e.tag, "mem_wdata", 32'(mem_wdata), 32'(e.wd));
      end
      if (e.ack) chk(e.tag, "iack_level", 32'(iack_level), 32'(e.al));
      if (e.srw) chk(e.tag, "sr_out", 32'(sr_out), 32'(e.sro));
      if (e.spw) chk(e.tag, "sp_out", sp_out, e.spo);
      if (e.pcw) chk(e.tag, "pc_out", pc_out, e.pco);
      if (e.vf)  chk(e.tag, "vec_addr", vec_addr, e.va);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_state(input logic [15:0] sr, input logic [31:0] pc);
    cpu_sr = sr; m_sr = sr; cpu_pc = pc; m_pc = pc;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      ram[i] = 16'(i * 3); m_mem[i] = 16'(i * 3);
    end
    m_sr = 16'h0300; m_pc = 32'h0000_4000; m_sp = STK_BASE + 32'h60;
    cpu_sr = m_sr; cpu_pc = m_pc; cpu_sp = m_sp;
    cyc(3);
    rst_n = 1'b1;
    cur_tag = "R1"; cyc(3);
    // R2: at or below the mask is ignored
    cur_tag = "R2"; req_level = 3'd3; cyc(4);
    req_level = 3'd2; cyc(3);
    // R2/R6 device vector, held request ignored after mask rises (R9)
    set_state(16'h0300, 32'h1234_5678);
    req_level = 3'd4; vec_num = 8'd70; cur_tag = "R9"; cyc(10);
    req_level = 3'd0; cyc(2);
    // R6 automatic vector
    set_state(16'h2400, 32'hCAFE_0010);
    cur_tag = "R6"; vec_auto = 1'b1; req_level = 3'd5; cyc(1);
    req_level = 3'd0; vec_auto = 1'b0;
    // R9: return command during busy is ignored
    cyc(1); rte_cmd = 1'b1; cyc(1); rte_cmd = 1'b0; cyc(4);
    // R8: two nested returns
    cur_tag = "R8"; rte_cmd = 1'b1; cyc(1); rte_cmd = 1'b0; cyc(5);
    rte_cmd = 1'b1; cyc(1); rte_cmd = 1'b0; cyc(5);
    // R3: level 7 under mask 7, held, then re-raised
    set_state(16'h2700, 32'h0000_7000);
    cur_tag = "R3"; req_level = 3'd7; cyc(12);
    req_level = 3'd0; cyc(1); req_level = 3'd7; cyc(6);
    req_level = 3'd0; cyc(1);
    rte_cmd = 1'b1; cyc(1); rte_cmd = 1'b0; cyc(5);
    rte_cmd = 1'b1; cyc(1); rte_cmd = 1'b0; cyc(5);
    // R3: rise while busy is remembered and beats a lower level
    set_state(16'h0000, 32'h0000_8000);
    req_level = 3'd2; cyc(2); req_level = 3'd7; cyc(1); req_level = 3'd2; cyc(8);
    req_level = 3'd0; cyc(2);
    // R10: return and request together
    cur_tag = "R10"; req_level = 3'd6; rte_cmd = 1'b1; cyc(1); rte_cmd = 1'b0;
    cyc(12); req_level = 3'd0; cyc(3);
    done = 1;
    report();
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      report();
      $finish;
    end
  end

endmodule